// File: doc/BRIEF.md
# Paged Register Command Decoder

This block turns 16-bit command words into accesses on a paged register map. Each word arrives on a parallel input, qualified by a one-cycle valid strobe. Bit 15 selects the kind of access. When it is 1, the word is a byte write. When it is 0, the word is a 16-bit read. Bits 14:8 carry a byte address and bits 7:0 carry the write data. The register storage sits outside the block. The decoder drives one-cycle write and read strobes toward it, together with page, address and data, and it samples the returned read word.

Address 0x00 holds a page register inside the decoder. Writing that address changes the page that every later access is tagged with. Reads are word-wide and pipelined: a read's data is presented on the response output, ready to be sent back during the following transfer. Writes present a zero response. A read of address 0x00 or 0x01 is answered locally with the current page number.

Top module: `paged_cmd_decoder`

## Requirements
- R1: After reset, `page_o`, `resp_word_o`, `wr_en_o` and `rd_en_o` are all zero.
- R2: A command with bit 15 = 1 and byte address (bits 14:8) of 2 or more raises `wr_en_o` for exactly one cycle, the cycle after `cmd_valid_i`. In that cycle `wr_addr_o` equals the address, `wr_data_o` equals bits 7:0 and `wr_page_o` equals the page.
- R3: A write to address 0x00 loads the low PAGE_W bits of the data byte into the page register, visible on `page_o` from the cycle after `cmd_valid_i`. It produces no `wr_en_o`.
- R4: A write to address 0x01 has no effect: no strobe is raised and `page_o` is unchanged.
- R5: A command with bit 15 = 0 and address of 2 or more raises `rd_en_o` for exactly one cycle, the cycle after `cmd_valid_i`. `rd_addr_o` equals the address with bit 0 cleared, and `rd_page_o` equals the page.
- R6: The `rd_data_i` value sampled during the `rd_en_o` cycle appears on `resp_word_o` from two cycles after `cmd_valid_i`.
- R7: A read of address 0x00 or 0x01 raises no `rd_en_o`. Two cycles after `cmd_valid_i`, `resp_word_o` equals the page number, zero-extended to 16 bits.
- R8: Any write command sets `resp_word_o` to 0x0000 two cycles after `cmd_valid_i`.
- R9: `resp_word_o` and `page_o` change only as a result of a command; they hold their values while no command is issued.
- R10: Each access is tagged with the page in effect before its own command. A page write affects only later commands.
- R11: `wr_en_o` and `rd_en_o` are never high in the same cycle, and neither is high without a command in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle strobe qualifying `cmd_word_i` |
| cmd_word_i | input | 16 | Command: [15] write, [14:8] byte address, [7:0] data |
| resp_word_o | output | 16 | Word to return during the next transfer |
| page_o | output | PAGE_W | Current page |
| wr_en_o | output | 1 | Byte write strobe to register storage |
| wr_page_o | output | PAGE_W | Page of the write |
| wr_addr_o | output | 7 | Byte address of the write |
| wr_data_o | output | 8 | Write data byte |
| rd_en_o | output | 1 | Word read strobe to register storage |
| rd_page_o | output | PAGE_W | Page of the read |
| rd_addr_o | output | 7 | Even byte address of the read |
| rd_data_i | input | 16 | Read word from storage, sampled while `rd_en_o` is high |

## Verification
The bench builds the decoder with PAGE_W = 3. This makes all eight pages reachable, and it lets page writes whose data byte has upper bits set exercise the truncation to the low bits. With that size it can sweep every page against every one of the 128 byte addresses, for both writes and reads. Storage is modelled by a read word computed arithmetically from page and address, so each response identifies exactly which page and even address was fetched.

// File: rtl/paged_cmd_pkg.sv
package paged_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int RESP_W = 16;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import paged_cmd_pkg::*;
(
  input  logic             valid_i,
  input  logic [CMD_W-1:0] word_i,
  output cmd_t             cmd_o,
  output logic             fwd_wr_o,
  output logic             fwd_rd_o,
  output logic             page_wr_o,
  output logic             loc_rd_o,
  output logic             any_wr_o
);
  logic low_addr;

  always_comb begin
    cmd_o     = cmd_t'(word_i);
    // addresses 0x00/0x01 belong to the page register
    low_addr  = (cmd_o.addr[ADDR_W-1:1] == '0);
    any_wr_o  = valid_i && cmd_o.wr;
    fwd_wr_o  = any_wr_o && !low_addr;
    page_wr_o = any_wr_o && (cmd_o.addr == '0);
    fwd_rd_o  = valid_i && !cmd_o.wr && !low_addr;
    loc_rd_o  = valid_i && !cmd_o.wr && low_addr;
  end
endmodule

// File: rtl/page_reg.sv
module page_reg
  import paged_cmd_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    page_o <= '0;
    else if (set_i) page_o <= data_i[PAGE_W-1:0];
  end

  assert_page_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(page_o));
endmodule

// File: rtl/resp_reg.sv
module resp_reg
  import paged_cmd_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              loc_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [RESP_W-1:0] rd_data_i,
  output logic [RESP_W-1:0] resp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    resp_o <= '0;
    else if (rd_i)  resp_o <= rd_data_i;
    else if (loc_i) resp_o <= RESP_W'(page_i);
    else if (wr_i)  resp_o <= '0;
  end

  assert_resp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !loc_i && !wr_i) |=> $stable(resp_o));
  assert_resp_wr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (resp_o == '0));
endmodule

// File: rtl/paged_cmd_decoder.sv
module paged_cmd_decoder
  import paged_cmd_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  output logic [RESP_W-1:0] resp_word_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              wr_en_o,
  output logic [PAGE_W-1:0] wr_page_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [PAGE_W-1:0] rd_page_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [RESP_W-1:0] rd_data_i
);
  cmd_t cmd;
  logic fwd_wr, fwd_rd, page_wr, loc_rd, any_wr;

  cmd_classify u_cls (
    .valid_i  (cmd_valid_i),
    .word_i   (cmd_word_i),
    .cmd_o    (cmd),
    .fwd_wr_o (fwd_wr),
    .fwd_rd_o (fwd_rd),
    .page_wr_o(page_wr),
    .loc_rd_o (loc_rd),
    .any_wr_o (any_wr)
  );

  page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (page_wr),
    .data_i(cmd.data),
    .page_o(page_o)
  );

  // access stage: snapshot of the page in force before this command
  logic              wr_q, rd_q, loc_q, anywr_q;
  logic [PAGE_W-1:0] pg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      loc_q   <= 1'b0;
      anywr_q <= 1'b0;
      pg_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      wr_q    <= fwd_wr;
      rd_q    <= fwd_rd;
      loc_q   <= loc_rd;
      anywr_q <= any_wr;
      if (cmd_valid_i) begin
        pg_q   <= page_o;
        addr_q <= cmd.wr ? cmd.addr : {cmd.addr[ADDR_W-1:1], 1'b0};
        data_q <= cmd.data;
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_page_o = pg_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign rd_en_o   = rd_q;
  assign rd_page_o = pg_q;
  assign rd_addr_o = addr_q;

  resp_reg #(.PAGE_W(PAGE_W)) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_q),
    .loc_i    (loc_q),
    .wr_i     (anywr_q),
    .page_i   (pg_q),
    .rd_data_i(rd_data_i),
    .resp_o   (resp_word_o)
  );

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && rd_en_o));
  assert_wr_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || !cmd_word_i[15]) |=> !wr_en_o);
  assert_rd_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_word_i[15]) |=> !rd_en_o);
  assert_wr_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[15] && cmd_word_i[14:9] != '0) |=>
      (wr_en_o && wr_addr_o == $past(cmd_word_i[14:8]) && wr_data_o == $past(cmd_word_i[7:0])));
  assert_rd_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_word_i[15] && cmd_word_i[14:9] != '0) |=>
      (rd_en_o && rd_addr_o == {$past(cmd_word_i[14:9]), 1'b0}));
  assert_page_snap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (wr_page_o == $past(page_o)));
  assert_page_wr_no_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[15] && cmd_word_i[14:9] == '0) |=> !wr_en_o);
endmodule

// File: tb/paged_cmd_decoder_test.sv
module paged_cmd_decoder_test;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [15:0]   cmd_word = '0;
  logic [15:0]   resp;
  logic [PW-1:0] page;
  logic          wr_en, rd_en;
  logic [PW-1:0] wr_page, rd_page;
  logic [6:0]    wr_addr, rd_addr;
  logic [7:0]    wr_data;
  logic [15:0]   rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // storage model: word identifies page and even address
  assign rd_data = {4'hA, 1'b0, rd_page, 1'b0, rd_addr};

  paged_cmd_decoder #(.PAGE_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .resp_word_o(resp), .page_o(page),
    .wr_en_o(wr_en), .wr_page_o(wr_page), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_page_o(rd_page), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one command; compare strobes next cycle, response the cycle after
  task automatic issue(input logic [15:0] w, input logic [PW-1:0] pg_before);
    logic [6:0]    a = w[14:8];
    logic          is_wr = w[15];
    logic          low = (a[6:1] == 6'd0);
    logic [PW-1:0] pg_after;
    logic [15:0]   exp_resp;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    pg_after = (is_wr && a == 7'd0) ? w[PW-1:0] : pg_before;
    chk(page == pg_after, is_wr && a == 7'd0 ? "R3 page load" : "R4/R10 page kept", 16'(page), 16'(pg_after));
    chk(!(wr_en && rd_en), "R11 exclusive", {wr_en, rd_en}, 16'd0);
    if (is_wr) begin
      chk(wr_en == !low, "R2/R3/R4 wr_en", 16'(wr_en), 16'(!low));
      chk(rd_en == 1'b0, "R11 no rd on write", 16'(rd_en), 16'd0);
      if (!low) begin
        chk(wr_addr == a, "R2 wr_addr", 16'(wr_addr), 16'(a));
        chk(wr_data == w[7:0], "R2 wr_data", 16'(wr_data), 16'(w[7:0]));
        chk(wr_page == pg_before, "R10 wr_page", 16'(wr_page), 16'(pg_before));
      end
      exp_resp = 16'h0000;
    end else begin
      chk(rd_en == !low, "R5/R7 rd_en", 16'(rd_en), 16'(!low));
      chk(wr_en == 1'b0, "R11 no wr on read", 16'(wr_en), 16'd0);
      if (!low) begin
        chk(rd_addr == {a[6:1], 1'b0}, "R5 rd_addr", 16'(rd_addr), 16'({a[6:1], 1'b0}));
        chk(rd_page == pg_before, "R10 rd_page", 16'(rd_page), 16'(pg_before));
        exp_resp = {4'hA, 1'b0, pg_before, 1'b0, a[6:1], 1'b0};
      end else begin
        exp_resp = 16'(pg_before);
      end
    end
    @(negedge clk);
    chk(wr_en == 1'b0 && rd_en == 1'b0, "R2/R5 single pulse", {wr_en, rd_en}, 16'd0);
    chk(resp == exp_resp, is_wr ? "R8 write resp" : (low ? "R7 page read" : "R6 read resp"), resp, exp_resp);
  endtask

  initial begin
    logic [PW-1:0] cur;
    logic [15:0]   hold;
    cur = '0;
    repeat (3) @(negedge clk);
    chk(page == 0 && resp == 0 && !wr_en && !rd_en, "R1 reset", resp, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(page == 0 && resp == 0 && !wr_en && !rd_en, "R1 after release", resp, 16'd0);
    for (int p = 0; p < 8; p++) begin
      logic [7:0] d = 8'(p) | 8'(p << 4);  // upper bits must be dropped
      issue({1'b1, 7'd0, d}, cur);
      cur = d[PW-1:0];
      issue({1'b0, 7'd0, 8'h55}, cur);
      issue({1'b1, 7'd1, 8'hFF}, cur);
      issue({1'b0, 7'd1, 8'h00}, cur);
      for (int a = 2; a < 128; a++) begin
        issue({1'b1, 7'(a), 8'(a * 3 + p)}, cur);
        issue({1'b0, 7'(a), 8'(p)}, cur);
      end
      hold = resp;
      repeat (3) @(negedge clk);
      chk(resp == hold, "R9 resp hold", resp, hold);
      chk(page == cur, "R9 page hold", 16'(page), 16'(cur));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule